// File: doc/BRIEF.md
# Multi-Source Interrupt Flag Controller

This block gathers six single-cycle event strobes: periodic, alarm, update-ended, wake-up, kickstart and RAM-clear. For each source it keeps one flag and one enable bit. It drives an active-low interrupt request as an open-drain pair. `irq_oe_o` high means "pull the line low", and `irq_lvl_o` is the constant level driven while it is enabled. The request is active while any flag is set together with its enable.

The periodic, alarm and update-ended flags sit in a status register that clears when read. A read cycle lasts as long as `rd_en_i` stays high with the status address presented at its start. During that time the flags are frozen. Events that arrive during the read are parked in a pending store and merged in when the read ends.

The wake-up, kickstart and RAM-clear flags sit in a separate extended register. Reading does not change them. Software clears one of them by writing 0 to its bit.

A two-state read sequencer handles the status register:

| State | Meaning |
|-------|---------|
| ST_IDLE | No status read in progress. |
| ST_HOLD | A status read is in progress. |

| Transition | From → To | Condition | Effect |
|------------|-----------|-----------|--------|
| START_READ | ST_IDLE → ST_HOLD | `rd_en_i` high with address 0 | Flags freeze; events go to the pending store. |
| STAY | ST_HOLD → ST_HOLD | `rd_en_i` still high | Flags stay frozen; events keep going to the pending store. |
| END_READ | ST_HOLD → ST_IDLE | `rd_en_i` low | Flags are replaced by the pending store OR the events of that cycle. |

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset all six flags and all six enables are 0, `irq_oe_o` is 0, and reads of addresses 0, 1 and 2 return 0x00.
- R2: An event sets its flag at the next clock edge whatever its enable bit holds, so the flag can be polled by a read. Event vector bits: 0 periodic, 1 alarm, 2 update-ended, 3 wake-up, 4 kickstart, 5 RAM-clear.
- R3: `irq_oe_o` is the OR over all sources of flag AND enable. It is combinational from the registers, so writing an enable for a flag that is already set asserts `irq_oe_o` in the cycle right after the write edge.
- R4: A read of address 0 returns the following, and `rdata_o` is 0x00 whenever `rd_en_i` is low.

  | Bit | Content |
  |-----|---------|
  | 7 | Combined request (IRQF) |
  | 6 | Periodic flag |
  | 5 | Alarm flag |
  | 4 | Update-ended flag |
  | 3–0 | Always 0 |

- R5: While a status read is in progress, the three status flags do not change and the read returns the same value on every cycle. In the first cycle with `rd_en_i` low, every status flag that was set is cleared.
- R6: A status event that arrives during a status read, including in its first cycle, is not lost. It sets its flag at the edge that ends the read. An event in the first cycle after the read (`rd_en_i` low) is also applied.
- R7: Address 2 reads the extended flags: bit 0 wake-up, bit 1 kickstart, bit 2 RAM-clear, with upper bits 0. Reading either address 0 or address 2 leaves these flags unchanged.
- R8: A write to address 2 clears each extended flag whose data bit is 0. A data bit of 1 has no effect. An event in the same cycle as the clearing write leaves its flag set.
- R9: Address 1 is a read/write enable register, with bits 0..5 mapped to sources in the same order as the event vector and bits 7..6 reading 0. Address 3 reads 0x00. Writes to addresses 0 and 3 have no effect.
- R10: `irq_lvl_o` is always 0. `irq_oe_o` returns to 0 once every enabled flag has been cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_i | input | 6 | Event strobes, one per source |
| rd_en_i | input | 1 | Read strobe; held high for the length of a read |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid while `rd_en_i` is high |
| irq_oe_o | output | 1 | High to pull the interrupt line low |
| irq_lvl_o | output | 1 | Level driven while enabled, constant 0 |

## Verification
`rdata_o` and `irq_oe_o` are combinational from the flag and enable registers. A read value is therefore due in the same cycle as the strobe. The effect of an event, a write or the end of a read is due in the cycle after the edge that captures it. The bench drives every input just after a falling edge and samples 2 ns later, before the next rising edge. It then advances its own model across that rising edge, so each expected value corresponds to exactly one register stage.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    parameter int unsigned SRC_N  = 6;
    parameter int unsigned STAT_N = 3;
    localparam int unsigned EXT_N = SRC_N - STAT_N;
    parameter int unsigned DW     = 8;
    parameter int unsigned AW     = 2;

    localparam logic [AW-1:0] ADR_STAT = 2'd0;
    localparam logic [AW-1:0] ADR_EN   = 2'd1;
    localparam logic [AW-1:0] ADR_EXT  = 2'd2;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } rd_state_e;
endpackage

// File: rtl/irqc_stat_flags.sv
module irqc_stat_flags
    import irqc_pkg::*;
#(
    parameter int unsigned N = STAT_N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev_i,
    input  logic         rd_start_i,
    input  logic         rd_en_i,
    output logic [N-1:0] flags_o
);
    rd_state_e    state_q, state_d;
    logic [N-1:0] flags_q, pend_q;
    logic         busy, release_rd;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state: START_READ, STAY, END_READ
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (rd_start_i) state_d = ST_HOLD;
            ST_HOLD: if (!rd_en_i)   state_d = ST_IDLE;
        endcase
    end

    // outputs of the sequencer
    always_comb begin
        busy       = 1'b0;
        release_rd = 1'b0;
        unique case (state_q)
            ST_IDLE: busy = rd_start_i;
            ST_HOLD: begin
                busy       = rd_en_i;
                release_rd = !rd_en_i;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
            pend_q  <= '0;
        end else if (release_rd) begin
            flags_q <= pend_q | ev_i;
            pend_q  <= '0;
        end else if (busy) begin
            pend_q  <= pend_q | ev_i;
        end else begin
            flags_q <= flags_q | ev_i;
        end
    end

    assign flags_o = flags_q;

    // R5: frozen during an ongoing read
    a_r5_frozen_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && rd_en_i) |=> $stable(flags_q));

    // R6: events of the closing cycle and deferred ones are kept
    a_r6_no_event_lost: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !rd_en_i) |=> ((flags_q & $past(ev_i)) == $past(ev_i)));

    // R2: outside a read an event sets its flag
    a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !rd_start_i) |=> ((flags_q & $past(ev_i)) == $past(ev_i)));

    // R5: the read ending with no events leaves nothing set
    a_r5_clear_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !rd_en_i && pend_q == '0 && ev_i == '0) |=> (flags_q == '0));
endmodule

// File: rtl/irqc_ext_flags.sv
module irqc_ext_flags
    import irqc_pkg::*;
#(
    parameter int unsigned N = EXT_N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev_i,
    input  logic         clr_we_i,
    input  logic [N-1:0] keep_mask_i,
    output logic [N-1:0] flags_o
);
    logic [N-1:0] flags_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic clr;
        assign clr = clr_we_i && !keep_mask_i[i];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flags_q[i] <= 1'b0;
            else        flags_q[i] <= (flags_q[i] && !clr) || ev_i[i];
        end

        // R8: event wins over a clearing write
        a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
            ev_i[i] |=> flags_q[i]);

        // R8: writing 1 leaves a set flag alone
        a_r8_one_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_we_i && keep_mask_i[i] && flags_q[i]) |=> flags_q[i]);

        // R7: without a write the flag persists
        a_r7_persist: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_we_i && flags_q[i]) |=> flags_q[i]);
    end

    assign flags_o = flags_q;
endmodule

// File: rtl/irqc_irq_gate.sv
module irqc_irq_gate
    import irqc_pkg::*;
#(
    parameter int unsigned N = SRC_N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_we_i,
    input  logic [N-1:0] en_wdata_i,
    input  logic [N-1:0] flags_i,
    output logic [N-1:0] en_o,
    output logic         irqf_o
);
    logic [N-1:0] en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       en_q <= '0;
        else if (en_we_i) en_q <= en_wdata_i;
    end

    assign en_o   = en_q;
    assign irqf_o = |(flags_i & en_q);

    // R9: enable register holds its value without a write
    a_r9_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en_we_i |=> $stable(en_q));

    // R3: a write enabling a set, unchanged flag requests at once
    a_r3_enable_immediate: assert property (@(posedge clk) disable iff (!rst_n)
        (en_we_i && |(en_wdata_i & flags_i)) |=> (irqf_o || !$stable(flags_i)));
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
    import irqc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [5:0]    ev_i,
    input  logic          rd_en_i,
    input  logic          wr_en_i,
    input  logic [1:0]    addr_i,
    input  logic [7:0]    wdata_i,
    output logic [7:0]    rdata_o,
    output logic          irq_oe_o,
    output logic          irq_lvl_o
);
    logic [STAT_N-1:0] stat_flags;
    logic [EXT_N-1:0]  ext_flags;
    logic [SRC_N-1:0]  en;
    logic              irqf;
    logic              unused_wbits;

    assign unused_wbits = ^wdata_i[DW-1:SRC_N];

    irqc_stat_flags #(.N(STAT_N)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_i       (ev_i[STAT_N-1:0]),
        .rd_start_i (rd_en_i && addr_i == ADR_STAT),
        .rd_en_i    (rd_en_i),
        .flags_o    (stat_flags)
    );

    irqc_ext_flags #(.N(EXT_N)) u_ext (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev_i        (ev_i[SRC_N-1:STAT_N]),
        .clr_we_i    (wr_en_i && addr_i == ADR_EXT),
        .keep_mask_i (wdata_i[EXT_N-1:0]),
        .flags_o     (ext_flags)
    );

    irqc_irq_gate #(.N(SRC_N)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_we_i    (wr_en_i && addr_i == ADR_EN),
        .en_wdata_i (wdata_i[SRC_N-1:0]),
        .flags_i    ({ext_flags, stat_flags}),
        .en_o       (en),
        .irqf_o     (irqf)
    );

    always_comb begin
        rdata_o = '0;
        if (rd_en_i) begin
            unique case (addr_i)
                ADR_STAT: rdata_o = {irqf, stat_flags[0], stat_flags[1], stat_flags[2], 4'b0000};
                ADR_EN:   rdata_o = {{(DW-SRC_N){1'b0}}, en};
                ADR_EXT:  rdata_o = {{(DW-EXT_N){1'b0}}, ext_flags};
                default:  rdata_o = '0;
            endcase
        end
    end

    assign irq_oe_o  = irqf;
    assign irq_lvl_o = 1'b0;

    // R4: status low nibble never set
    a_r4_low_nibble_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && addr_i == ADR_STAT) |-> (rdata_o[3:0] == 4'b0000));

    // R10: request held while an enabled extended flag remains and no clear is written
    a_r10_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ext_flags & en[SRC_N-1:STAT_N]) && !wr_en_i) |=> irq_oe_o);
endmodule

// File: tb/irq_flag_ctrl_tb.sv
module irq_flag_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [5:0] ev;
    logic       rd, wr;
    logic [1:0] a;
    logic [7:0] wd;
    logic [7:0] rdata;
    logic       irq_oe, irq_lvl;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [2:0] m_stat, m_pend, m_ext;
    logic [5:0] m_en;
    logic       m_hold;
    logic [7:0] s_rdata;
    logic       s_irq;

    always #4 clk = ~clk;

    irq_flag_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .ev_i(ev), .rd_en_i(rd), .wr_en_i(wr),
        .addr_i(a), .wdata_i(wd), .rdata_o(rdata), .irq_oe_o(irq_oe), .irq_lvl_o(irq_lvl)
    );

    function automatic logic m_irqf();
        return |({m_ext, m_stat} & m_en);
    endfunction

    function automatic logic [7:0] exp_rdata(input logic r, input logic [1:0] ad);
        if (!r) return 8'h00;
        case (ad)
            2'd0:    return {m_irqf(), m_stat[0], m_stat[1], m_stat[2], 4'b0000};
            2'd1:    return {2'b00, m_en};
            2'd2:    return {5'b00000, m_ext};
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [5:0] e, input logic r, input logic [1:0] ad,
                        input logic w, input logic [7:0] d, input string tag);
        logic busy, rel;
        @(negedge clk);
        ev = e; rd = r; a = ad; wr = w; wd = d;
        #2;
        s_rdata = rdata;
        s_irq   = irq_oe;
        if (r) chk({tag, " rdata (R4)"}, rdata, exp_rdata(r, ad));
        chk({tag, " irq (R3)"}, {7'b0, irq_oe}, {7'b0, m_irqf()});
        chk({tag, " lvl (R10)"}, {7'b0, irq_lvl}, 8'h00);
        @(posedge clk);
        busy = (!m_hold && r && ad == 2'd0) || (m_hold && r);
        rel  = m_hold && !r;
        if (rel) begin
            m_stat = m_pend | e[2:0]; m_pend = 3'b0; m_hold = 1'b0;
        end else if (busy) begin
            m_pend = m_pend | e[2:0]; m_hold = 1'b1;
        end else begin
            m_stat = m_stat | e[2:0];
        end
        if (w && ad == 2'd2) m_ext = m_ext & d[2:0];
        m_ext = m_ext | e[5:3];
        if (w && ad == 2'd1) m_en = d[5:0];
    endtask

    task automatic idle(input string tag);
        step(6'b0, 1'b0, 2'd0, 1'b0, 8'h00, tag);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        int rlen;
        logic [1:0] ra;
        seed = $urandom(32'h5EED_1234);
        ev = '0; rd = 0; wr = 0; a = 0; wd = 0;
        m_stat = 0; m_pend = 0; m_ext = 0; m_en = 0; m_hold = 0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        step(6'b0, 1, 2'd0, 0, 8'h00, "R1 stat"); chk("R1 stat", s_rdata, 8'h00);
        idle("R1");
        step(6'b0, 1, 2'd1, 0, 8'h00, "R1 en");   chk("R1 en", s_rdata, 8'h00);
        step(6'b0, 1, 2'd2, 0, 8'h00, "R1 ext");  chk("R1 ext", s_rdata, 8'h00);
        chk("R1 irq", {7'b0, s_irq}, 8'h00);
        idle("R1");

        // R2 flag set without enable
        step(6'b000001, 0, 2'd0, 0, 8'h00, "R2 ev");
        step(6'b0, 1, 2'd0, 0, 8'h00, "R2 poll"); chk("R2 poll periodic", s_rdata, 8'h40);
        chk("R2 no irq", {7'b0, s_irq}, 8'h00);
        idle("R5 end");
        step(6'b0, 1, 2'd0, 0, 8'h00, "R5 cleared"); chk("R5 cleared", s_rdata, 8'h00);
        idle("R5");

        // R3 enabling a set flag
        step(6'b000010, 0, 2'd0, 0, 8'h00, "R3 alarm");
        step(6'b0, 0, 2'd1, 1, 8'h02, "R3 en write");
        idle("R3"); chk("R3 immediate irq", {7'b0, s_irq}, 8'h01);

        // R5 R6 multi-cycle read with deferred update event
        step(6'b000100, 1, 2'd0, 0, 8'h00, "R5 read1"); chk("R4 IRQF+alarm", s_rdata, 8'hA0);
        step(6'b0, 1, 2'd0, 0, 8'h00, "R5 read2");      chk("R5 frozen", s_rdata, 8'hA0);
        idle("R6 end");
        step(6'b0, 1, 2'd0, 0, 8'h00, "R6 deferred");   chk("R6 deferred update", s_rdata, 8'h10);
        chk("R10 released", {7'b0, s_irq}, 8'h00);
        idle("R6");

        // R7 R8 extended flags
        step(6'b001000, 0, 2'd0, 0, 8'h00, "R7 wake");
        step(6'b0, 1, 2'd2, 0, 8'h00, "R7 read"); chk("R7 wake bit0", s_rdata, 8'h01);
        step(6'b0, 1, 2'd0, 0, 8'h00, "R7 stat read");
        idle("R7");
        step(6'b0, 1, 2'd2, 0, 8'h00, "R7 kept"); chk("R7 not cleared by read", s_rdata, 8'h01);
        step(6'b0, 0, 2'd1, 1, 8'h08, "R8 en wake");
        idle("R8"); chk("R3 wake irq", {7'b0, s_irq}, 8'h01);
        step(6'b0, 0, 2'd2, 1, 8'hFF, "R8 write ones");
        step(6'b0, 1, 2'd2, 0, 8'h00, "R8 ones"); chk("R8 ones no effect", s_rdata, 8'h01);
        step(6'b001000, 0, 2'd2, 1, 8'hFE, "R8 race");
        step(6'b0, 1, 2'd2, 0, 8'h00, "R8 race"); chk("R8 event wins", s_rdata, 8'h01);
        step(6'b0, 0, 2'd2, 1, 8'hFE, "R8 clear");
        step(6'b0, 1, 2'd2, 0, 8'h00, "R8 cleared"); chk("R8 cleared", s_rdata, 8'h00);
        chk("R10 irq off", {7'b0, s_irq}, 8'h00);
        step(6'b110000, 0, 2'd0, 0, 8'h00, "R7 kick ram");
        step(6'b0, 1, 2'd2, 0, 8'h00, "R7 pos"); chk("R7 kick+ramclr", s_rdata, 8'h06);

        // R9 enable register and unused address
        step(6'b0, 0, 2'd1, 1, 8'hFF, "R9 en write");
        step(6'b0, 1, 2'd1, 0, 8'h00, "R9 en read"); chk("R9 readback", s_rdata, 8'h3F);
        step(6'b0, 0, 2'd3, 1, 8'hFF, "R9 addr3 write");
        step(6'b0, 0, 2'd0, 1, 8'hFF, "R9 addr0 write");
        step(6'b0, 1, 2'd3, 0, 8'h00, "R9 addr3"); chk("R9 addr3 zero", s_rdata, 8'h00);
        step(6'b0, 1, 2'd1, 0, 8'h00, "R9 en kept"); chk("R9 en unchanged", s_rdata, 8'h3F);
        step(6'b0, 0, 2'd2, 1, 8'h00, "R10 clear all");
        idle("R10"); chk("R10 irq off after clear", {7'b0, s_irq}, 8'h00);

        // random phase
        rlen = 0; ra = 0;
        for (int i = 0; i < 4000; i++) begin
            logic [5:0] e;
            int op;
            e = 6'($urandom & $urandom & $urandom);
            if (rlen > 0) begin
                rlen--;
                step(e, 1, ra, 0, 8'h00, "R5 R6 rnd read");
            end else begin
                op = $urandom % 8;
                if (op < 3) begin
                    ra = 2'($urandom);
                    rlen = $urandom % 3;
                    step(e, 1, ra, 0, 8'h00, "R4 rnd read");
                end else if (op == 3) begin
                    step(e, 0, 2'd1, 1, 8'($urandom), "R9 rnd en");
                end else if (op == 4) begin
                    step(e, 0, 2'd2, 1, 8'($urandom), "R8 rnd ext");
                end else begin
                    step(e, 0, 2'd0, 0, 8'h00, "R2 rnd idle");
                end
            end
        end
        idle("end");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule